// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a watchdog for a system clock domain. A slow tick strobe, nominally 1 kHz, paces a counter. When software fails to restart the counter before the selected timeout, the block raises a one-cycle reset request. An optional window mode adds a closed interval at the start of every period. A restart that arrives inside that interval counts as a fault and raises the same reset request.

Configuration is guarded in two ways. First, a key value written to the key register opens a write window a few system clocks long. Second, each configuration register carries a change bit, and its fields are updated only when that bit is one in the same write. An accepted configuration write is held in a staging copy and a busy flag is raised. On the next tick the staging copy moves into the live configuration and the busy flag drops. This models the hand-over into the slow watchdog domain.

Top module: `wdt_window_top`

## Requirements
- R1: After reset the reset request is low, the busy flag is low, and the watchdog is disabled (no request is ever produced until enabled).
- R2: Address 0 is the key register. Writing 0xC3 to it opens a window of 4 system clocks: writes to address 1 (control) or address 2 (window control) in any of the 4 cycles after the key write are accepted, and later writes are ignored.
- R3: In both configuration registers, bit 0 is the change bit, bit 1 is the enable and bits 5:2 are the period code. The fields update only when bit 0 is one in the same write; an accepted write with bit 0 at zero raises busy but leaves the configuration unchanged.
- R4: Busy rises in the cycle after an accepted configuration write. It falls after the next tick, and on that tick the staged configuration becomes live and the count restarts from zero.
- R5: Configuration writes that arrive while busy is high are ignored.
- R6: Period code c selects 2^(c+3) ticks; codes 11 to 15 select 8192 ticks.
- R7: In normal mode, with the watchdog enabled, the request pulses for one cycle in the cycle after the P-th tick since the last restart, and the count then restarts.
- R8: A restart strobe clears the count, so the next timeout comes P ticks after it.
- R9: With window enabled (window period W), a restart when fewer than W ticks have passed since the last restart pulses the request in the next cycle. With no restart, the timeout comes on the (W+P)-th tick.
- R10: With window enabled, a restart when W or more ticks have passed produces no request and clears the count.
- R11: While disabled, neither ticks nor restarts produce a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle strobe from the slow time base |
| kick_i | input | 1 | One-cycle restart strobe from software |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address: 0 key, 1 control, 2 window control |
| wr_data_i | input | DATA_W | Register write data |
| busy_o | output | 1 | A configuration write is waiting for the next tick |
| wdt_rst_o | output | 1 | One-cycle reset request |

## Verification
The assertions watch several rules on every cycle. A configuration write made outside the key window never raises busy, and an accepted write always does. Busy falls only on a tick. A request never follows a cycle in which the watchdog was disabled. A request is always preceded by a tick or a restart. Only the bench scenarios can show the exact tick on which a timeout lands for each period code, including the clamp above code 10. The same holds for the early and late restart boundaries of the window, for busy writes being dropped, and for the change bit's effect on the live configuration.

// File: rtl/wdt_pkg.sv
`timescale 1ns/1ps
package wdt_pkg;
  localparam int CODE_W   = 4;
  localparam int CODE_MAX = 10;
  localparam int BASE_LOG = 3;
  localparam int CNT_W    = CODE_MAX + BASE_LOG + 2;
  localparam int ADDR_W   = 2;

  localparam logic [ADDR_W-1:0] ADDR_KEY  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_WIN  = 2'd2;

  localparam int BIT_CHG  = 0;
  localparam int BIT_EN   = 1;
  localparam int BIT_CODE = 2;

  typedef struct packed {
    logic              en;
    logic [CODE_W-1:0] code;
  } wdt_field_t;

  typedef struct packed {
    wdt_field_t tmo;
    wdt_field_t win;
  } wdt_cfg_t;

  // Tick count selected by a period code, clamped at CODE_MAX.
  function automatic logic [CNT_W-1:0] code_ticks(input logic [CODE_W-1:0] code);
    int sh;
    sh = (int'(code) > CODE_MAX) ? CODE_MAX : int'(code);
    return CNT_W'(1) << (sh + BASE_LOG);
  endfunction
endpackage

// File: rtl/wdt_cfg_port.sv
`timescale 1ns/1ps
module wdt_cfg_port
  import wdt_pkg::*;
#(
  parameter int              DATA_W     = 8,
  parameter int              UNLOCK_CYC = 4,
  parameter logic [DATA_W-1:0] KEY_VAL  = DATA_W'('hC3)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              tick_i,
  output logic              busy_o,
  output logic              apply_o,
  output wdt_cfg_t          live_o
);
  localparam int KC_W = $clog2(UNLOCK_CYC + 1);

  logic [KC_W-1:0] key_q, key_d;
  logic            busy_q, busy_d;
  wdt_cfg_t        shadow_q, shadow_d;
  wdt_cfg_t        live_q, live_d;
  logic            key_hit, wr_ok, ctrl_acc, win_acc, chg;
  wdt_field_t      new_field;

  assign key_hit  = wr_en_i && (wr_addr_i == ADDR_KEY) && (wr_data_i == KEY_VAL);
  assign wr_ok    = wr_en_i && (key_q != '0) && !busy_q;
  assign ctrl_acc = wr_ok && (wr_addr_i == ADDR_CTRL);
  assign win_acc  = wr_ok && (wr_addr_i == ADDR_WIN);
  assign chg      = wr_data_i[BIT_CHG];
  assign apply_o  = tick_i && busy_q;

  always_comb begin
    new_field.en   = wr_data_i[BIT_EN];
    new_field.code = wr_data_i[BIT_CODE +: CODE_W];

    key_d = key_q;
    if (key_q != '0) key_d = key_q - KC_W'(1);
    if (key_hit)     key_d = KC_W'(UNLOCK_CYC);

    shadow_d = shadow_q;
    if (ctrl_acc && chg) shadow_d.tmo = new_field;
    if (win_acc && chg)  shadow_d.win = new_field;

    busy_d = busy_q;
    if (ctrl_acc || win_acc) busy_d = 1'b1;
    else if (apply_o)        busy_d = 1'b0;

    live_d = apply_o ? shadow_q : live_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      key_q    <= '0;
      busy_q   <= 1'b0;
      shadow_q <= '0;
      live_q   <= '0;
    end else begin
      key_q    <= key_d;
      busy_q   <= busy_d;
      shadow_q <= shadow_d;
      live_q   <= live_d;
    end
  end

  assign busy_o = busy_q;
  assign live_o = live_q;
endmodule

// File: rtl/wdt_core.sv
`timescale 1ns/1ps
module wdt_core
  import wdt_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  wdt_cfg_t cfg_i,
  input  logic     apply_i,
  input  logic     tick_i,
  input  logic     kick_i,
  output logic     rst_req_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] per_ticks, win_ticks, limit;
  logic             req_q, req_d, early;

  assign per_ticks = code_ticks(cfg_i.tmo.code);
  assign win_ticks = cfg_i.win.en ? code_ticks(cfg_i.win.code) : '0;
  assign limit     = per_ticks + win_ticks;
  assign early     = cfg_i.win.en && (cnt_q < win_ticks);

  always_comb begin
    cnt_d = cnt_q;
    req_d = 1'b0;
    if (!cfg_i.tmo.en || apply_i) begin
      cnt_d = '0;
    end else if (kick_i) begin
      cnt_d = '0;
      req_d = early;
    end else if (tick_i) begin
      if (cnt_q == limit - CNT_W'(1)) begin
        cnt_d = '0;
        req_d = 1'b1;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      req_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      req_q <= req_d;
    end
  end

  assign rst_req_o = req_q;
endmodule

// File: rtl/wdt_window_top.sv
`timescale 1ns/1ps
module wdt_window_top
  import wdt_pkg::*;
#(
  parameter int                DATA_W     = 8,
  parameter int                UNLOCK_CYC = 4,
  parameter logic [DATA_W-1:0] KEY_VAL    = DATA_W'('hC3)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              kick_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              busy_o,
  output logic              wdt_rst_o
);
  logic [1:0] rst_sync_q;
  logic       rst_n_sync;
  wdt_cfg_t   live_cfg;
  logic       apply;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_sync = rst_sync_q[1];

  wdt_cfg_port #(
    .DATA_W    (DATA_W),
    .UNLOCK_CYC(UNLOCK_CYC),
    .KEY_VAL   (KEY_VAL)
  ) cfg_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_n_sync),
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i),
    .tick_i   (tick_i),
    .busy_o   (busy_o),
    .apply_o  (apply),
    .live_o   (live_cfg)
  );

  wdt_core core_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_n_sync),
    .cfg_i    (live_cfg),
    .apply_i  (apply),
    .tick_i   (tick_i),
    .kick_i   (kick_i),
    .rst_req_o(wdt_rst_o)
  );
endmodule

// File: rtl/wdt_window_chk.sv
`timescale 1ns/1ps
module wdt_window_chk
  import wdt_pkg::*;
#(
  parameter int                DATA_W     = 8,
  parameter int                UNLOCK_CYC = 4,
  parameter logic [DATA_W-1:0] KEY_VAL    = DATA_W'('hC3)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              kick_i,
  input logic              wr_en_i,
  input logic [1:0]        wr_addr_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic              busy_o,
  input logic              wdt_rst_o,
  input wdt_cfg_t          live_i
);
  localparam int KC_W = $clog2(UNLOCK_CYC + 1);

  logic [KC_W-1:0] open_q;
  logic            cfg_wr;

  assign cfg_wr = wr_en_i && ((wr_addr_i == ADDR_CTRL) || (wr_addr_i == ADDR_WIN));

  // Independent tracker of the key window.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) open_q <= '0;
    else if (wr_en_i && (wr_addr_i == ADDR_KEY) && (wr_data_i == KEY_VAL))
      open_q <= KC_W'(UNLOCK_CYC);
    else if (open_q != '0)
      open_q <= open_q - KC_W'(1);
  end

  a_r2_locked_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_wr && (open_q == '0) && !busy_o) |=> !busy_o);

  a_r4_accepted_write_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_wr && (open_q != '0) && !busy_o) |=> busy_o);

  a_r4_busy_falls_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(tick_i));

  a_r11_disabled_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !live_i.tmo.en |=> !wdt_rst_o);

  a_r7_request_has_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_rst_o |-> $past(tick_i || kick_i));
endmodule

bind wdt_window_top wdt_window_chk #(
  .DATA_W    (DATA_W),
  .UNLOCK_CYC(UNLOCK_CYC),
  .KEY_VAL   (KEY_VAL)
) chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_n_sync),
  .tick_i   (tick_i),
  .kick_i   (kick_i),
  .wr_en_i  (wr_en_i),
  .wr_addr_i(wr_addr_i),
  .wr_data_i(wr_data_i),
  .busy_o   (busy_o),
  .wdt_rst_o(wdt_rst_o),
  .live_i   (live_cfg)
);

// File: tb/wdt_window_top_tb_top.sv
`timescale 1ns/1ps
module wdt_window_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, kick = 1'b0, we = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] data = 8'd0;
  logic       busy, wdt_rst;

  int cyc = 0;
  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;
  int unsigned exp_q[$];

  always #5 clk = ~clk;

  wdt_window_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .kick_i(kick),
    .wr_en_i(we), .wr_addr_i(addr), .wr_data_i(data),
    .busy_o(busy), .wdt_rst_o(wdt_rst)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: every request pulse must match the front of the expected queue.
  always @(negedge clk) begin
    if (exp_q.size() != 0 && exp_q[0] == cyc) begin
      void'(exp_q.pop_front());
      vectors++;
      if (wdt_rst !== 1'b1) begin
        fails++;
        $display("FAIL R7 missing reset request at cycle %0d actual=%b expected=1", cyc, wdt_rst);
      end
    end else if (wdt_rst !== 1'b0) begin
      vectors++;
      fails++;
      $display("FAIL R11 unexpected reset request at cycle %0d actual=%b expected=0", cyc, wdt_rst);
    end
  end

  // Driver: set inputs for the coming edge; a pulse caused by that edge is
  // observed at the next falling edge, when cyc has advanced by one.
  task automatic step(input logic tk, input logic kk, input logic w,
                      input logic [1:0] a, input logic [7:0] d, input bit exp);
    @(negedge clk);
    tick = tk; kick = kk; we = w; addr = a; data = d;
    if (exp) exp_q.push_back(cyc + 1);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 2'd0, 8'd0, 0);
  endtask

  task automatic ticks(input int n, input bit exp_last);
    for (int i = 1; i <= n; i++) step(1, 0, 0, 2'd0, 8'd0, exp_last && (i == n));
  endtask

  task automatic unlock();
    step(0, 0, 1, 2'd0, 8'hC3, 0);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    step(0, 0, 1, a, d, 0);
  endtask

  task automatic chk_busy(input logic exp, input string tag);
    @(negedge clk);
    tick = 0; kick = 0; we = 0; addr = 2'd0; data = 8'd0;
    vectors++;
    if (busy !== exp) begin
      fails++;
      $display("FAIL %s busy actual=%b expected=%b", tag, busy, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    idle(4);
    chk_busy(0, "R1");
    ticks(20, 0);                     // R1: disabled after reset, no request

    wr(2'd1, 8'h03);                  // no key
    chk_busy(0, "R2");
    ticks(12, 0);

    // R4, R5, R6: period code 1 (16 ticks); second write while busy dropped.
    unlock();
    wr(2'd1, 8'h07);
    chk_busy(1, "R4");
    wr(2'd1, 8'h03);
    chk_busy(1, "R5");
    step(1, 0, 0, 2'd0, 8'd0, 0);     // apply tick
    chk_busy(0, "R4");
    ticks(16, 1);                     // R5 R6: timeout on the 16th tick
    ticks(16, 1);                     // R7: periodic timeout
    ticks(10, 0);
    step(0, 1, 0, 2'd0, 8'd0, 0);     // R8: restart
    ticks(16, 1);

    // R2: write one cycle after the window closes is ignored.
    unlock();
    idle(4);
    wr(2'd1, 8'h03);
    chk_busy(0, "R2");
    unlock();
    idle(3);
    wr(2'd1, 8'h03);                  // last cycle of the window
    chk_busy(1, "R2");
    step(1, 0, 0, 2'd0, 8'd0, 0);
    ticks(8, 1);                      // R6: code 0 gives 8 ticks

    // R3: change bit clear leaves the configuration (still enabled).
    unlock();
    wr(2'd1, 8'h00);
    chk_busy(1, "R3");
    step(1, 0, 0, 2'd0, 8'd0, 0);
    chk_busy(0, "R3");
    ticks(8, 1);                      // R3: still times out after 8 ticks

    // R9, R10: window code 0 (8 ticks), period 8 ticks.
    unlock();
    wr(2'd2, 8'h03);
    step(1, 0, 0, 2'd0, 8'd0, 0);
    ticks(3, 0);
    step(0, 1, 0, 2'd0, 8'd0, 1);     // R9: early restart
    ticks(7, 0);
    step(0, 1, 0, 2'd0, 8'd0, 1);     // R9: boundary, 7 ticks still early
    ticks(8, 0);
    step(0, 1, 0, 2'd0, 8'd0, 0);     // R10: restart at 8 ticks is allowed
    ticks(16, 1);                     // R9: timeout after W+P ticks

    // R6: code 12 clamps to 8192 ticks, window off.
    unlock();
    wr(2'd2, 8'h01);
    step(1, 0, 0, 2'd0, 8'd0, 0);
    unlock();
    wr(2'd1, 8'h33);
    step(1, 0, 0, 2'd0, 8'd0, 0);
    ticks(8192, 1);

    // R11: disabled, ticks and restarts produce nothing.
    unlock();
    wr(2'd1, 8'h01);
    step(1, 0, 0, 2'd0, 8'd0, 0);
    ticks(30, 0);
    step(0, 1, 0, 2'd0, 8'd0, 0);
    idle(4);

    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R7 pending expected requests actual=%0d expected=0", exp_q.size());
    end
    finish_run();
  end
endmodule